// File: doc/BRIEF.md
# Trap Entry Control Unit

This unit performs the architectural state change that happens when a hart takes a trap, whether that trap is a synchronous exception or an asynchronous interrupt. The surrounding pipeline presents the following in a single cycle with `trap_valid_i` high:

- the trap kind and its raw cause number;
- the faulting address;
- the current pc and privilege;
- the current status bits;
- both delegation masks and both trap-vector registers.

The unit first recodes a generic environment call according to the current privilege. It then decides whether supervisor or machine mode handles the trap. On the same clock edge it commits the following for the chosen mode:

- the interrupt-enable stack;
- the previous-privilege field;
- the cause, exception pc and trap value registers;
- the new pc and the new privilege.

A one-cycle done pulse follows in the cycle after the request.

Privilege levels are encoded as user 0, supervisor 1 and machine 3. The block holds the committed values as registers and drives them on its outputs. Returning from a trap and software access to these registers are handled elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: After synchronous reset the unit drives privilege 3 (machine), pc equal to `RESET_PC`, and all status bits low. It also drives all six cause, exception pc and trap value registers as zero, with `done_o` low.
- R2: An interrupt (`async_i`=1) looks up its cause bit in `ideleg_i`. An exception (`async_i`=0) looks it up in `edeleg_i`.
- R3: The trap is handled in supervisor mode (privilege becomes 1) only when all three conditions hold. First, the current privilege is 0 or 1. Second, the recoded cause is below XLEN. Third, the selected delegation bit at that cause is 1. In every other case it is handled in machine mode (privilege becomes 3).
- R4: A supervisor trap copies the old SIE into SPIE, copies bit 0 of the current privilege into SPP and clears SIE. It loads the pc into the supervisor exception pc register. MIE, MPIE and MPP take their input values unchanged.
- R5: A machine trap copies the old MIE into MPIE, copies the 2-bit current privilege into MPP and clears MIE. It loads the pc into the machine exception pc register. SIE, SPIE and SPP take their input values unchanged.
- R6: The cause register of the handling mode receives the recoded cause zero-extended, with bit XLEN-1 set for an interrupt and clear for an exception.
- R7: The new pc is the handling mode's trap-vector value with bits 1:0 cleared. When those two low bits equal 1 and the trap is an interrupt, four times the recoded cause is added to it.
- R8: The trap value register of the handling mode receives the faulting address for exceptions with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other exception, and for all interrupts, it receives zero.
- R9: An exception with raw cause 8 is recoded to 8 plus the current privilege before delegation is evaluated: 8 from user, 9 from supervisor, 11 from machine.
- R10: The cause, exception pc and trap value registers of the mode that does not handle the trap keep their values. In cycles without `trap_valid_i` every output except `done_o` keeps its value.
- R11: `done_o` is high in exactly the cycle after each cycle in which `trap_valid_i` was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trap_valid_i | input | 1 | Take a trap this cycle |
| async_i | input | 1 | 1 for interrupt, 0 for exception |
| cause_i | input | CW | Raw cause number |
| badaddr_i | input | XLEN | Faulting address |
| pc_i | input | XLEN | pc of the trapping instruction |
| priv_i | input | 2 | Current privilege |
| sie_i | input | 1 | Current supervisor interrupt enable |
| spie_i | input | 1 | Current supervisor previous enable |
| spp_i | input | 1 | Current supervisor previous privilege |
| mie_i | input | 1 | Current machine interrupt enable |
| mpie_i | input | 1 | Current machine previous enable |
| mpp_i | input | 2 | Current machine previous privilege |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| edeleg_i | input | XLEN | Exception delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector, mode in bits 1:0 |
| mtvec_i | input | XLEN | Machine trap vector, mode in bits 1:0 |
| pc_o | output | XLEN | Committed next pc |
| priv_o | output | 2 | Committed privilege |
| sie_o | output | 1 | Committed SIE |
| spie_o | output | 1 | Committed SPIE |
| spp_o | output | 1 | Committed SPP |
| mie_o | output | 1 | Committed MIE |
| mpie_o | output | 1 | Committed MPIE |
| mpp_o | output | 2 | Committed MPP |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor exception pc |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception pc |
| mtval_o | output | XLEN | Machine trap value |
| done_o | output | 1 | Commit pulse, one cycle after the request |

## Verification
The environment-call recoding and the delegation decision act in the same cycle. The recoded cause, not the raw one, selects the delegation bit. Directed cases raise cause 8 from supervisor with only bit 9 delegated, and from user with only bit 8 delegated. They check that the first lands in supervisor mode with cause 9 and the second with cause 8, and that a machine-mode call stays in machine mode with cause 11. Random vectors with a fixed seed mix these cases with interrupts whose causes exceed XLEN and with vectored trap bases. Every output is compared against a bench model after each commit edge.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef logic [1:0] priv_t;

    localparam priv_t PRIV_U = 2'd0;
    localparam priv_t PRIV_S = 2'd1;
    localparam priv_t PRIV_M = 2'd3;

    // raw cause value that stands for any environment call
    localparam int unsigned ECALL_RAW = 8;

    // trap-vector mode value that enables per-cause offsets
    localparam logic [1:0] VEC_MODE_SPREAD = 2'b01;

    typedef struct packed {
        logic       sie;
        logic       spie;
        logic       spp;
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
    } stack_t;

    // exceptions that report the faulting address in the trap value register
    function automatic logic reports_address(input int unsigned code);
        case (code)
            0, 1, 4, 5, 6, 7, 12, 13, 15: reports_address = 1'b1;
            default:                      reports_address = 1'b0;
        endcase
    endfunction

    // push the enable stack of the handling mode
    function automatic stack_t push_stack(input stack_t cur, input priv_t from,
                                          input logic to_super);
        stack_t nx;
        nx = cur;
        if (to_super) begin
            nx.spie = cur.sie;
            nx.spp  = from[0];
            nx.sie  = 1'b0;
        end else begin
            nx.mpie = cur.mie;
            nx.mpp  = from;
            nx.mie  = 1'b0;
        end
        return nx;
    endfunction

endpackage

// File: rtl/trap_classify.sv
module trap_classify
    import trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = 6
) (
    input  logic            async_i,
    input  logic [CW-1:0]   cause_i,
    input  priv_t           priv_i,
    input  logic [XLEN-1:0] badaddr_i,
    output logic [CW-1:0]   cause_o,
    output logic [XLEN-1:0] tval_o
);
    logic is_ecall;

    always_comb begin
        is_ecall = !async_i && (cause_i == CW'(ECALL_RAW));
        cause_o  = is_ecall ? (cause_i + CW'(priv_i)) : cause_i;
        if (!async_i && reports_address(32'(cause_o)))
            tval_o = badaddr_i;
        else
            tval_o = '0;
    end
endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = 6
) (
    input  logic            async_i,
    input  logic [CW-1:0]   cause_i,
    input  priv_t           priv_i,
    input  logic [XLEN-1:0] ideleg_i,
    input  logic [XLEN-1:0] edeleg_i,
    output logic            to_super_o
);
    localparam int IW = $clog2(XLEN);

    logic            in_range;
    logic [XLEN-1:0] mask;
    logic            low_priv;

    generate
        if (CW > IW) begin : g_wide_cause
            assign in_range = (cause_i[CW-1:IW] == '0);
        end else begin : g_narrow_cause
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        mask       = async_i ? ideleg_i : edeleg_i;
        low_priv   = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        to_super_o = low_priv && in_range && mask[IW'(cause_i)];
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = 6
) (
    input  logic            async_i,
    input  logic [CW-1:0]   cause_i,
    input  logic [XLEN-1:0] tvec_i,
    output logic [XLEN-1:0] target_o
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {tvec_i[XLEN-1:2], 2'b00};
        offset = (async_i && tvec_i[1:0] == VEC_MODE_SPREAD)
                 ? (XLEN'(cause_i) << 2) : '0;
        target_o = base + offset;
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          CW       = 6,
    parameter int unsigned RESET_PC = 32'h0000_0100
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            trap_valid_i,
    input  logic            async_i,
    input  logic [CW-1:0]   cause_i,
    input  logic [XLEN-1:0] badaddr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [1:0]      priv_i,
    input  logic            sie_i,
    input  logic            spie_i,
    input  logic            spp_i,
    input  logic            mie_i,
    input  logic            mpie_i,
    input  logic [1:0]      mpp_i,
    input  logic [XLEN-1:0] ideleg_i,
    input  logic [XLEN-1:0] edeleg_i,
    input  logic [XLEN-1:0] stvec_i,
    input  logic [XLEN-1:0] mtvec_i,
    output logic [XLEN-1:0] pc_o,
    output logic [1:0]      priv_o,
    output logic            sie_o,
    output logic            spie_o,
    output logic            spp_o,
    output logic            mie_o,
    output logic            mpie_o,
    output logic [1:0]      mpp_o,
    output logic [XLEN-1:0] scause_o,
    output logic [XLEN-1:0] sepc_o,
    output logic [XLEN-1:0] stval_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mtval_o,
    output logic            done_o
);
    localparam int PAD_W = XLEN - 1 - CW;

    logic [CW-1:0]   code;
    logic [XLEN-1:0] tval;
    logic            to_super;
    logic [XLEN-1:0] tvec_sel;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] cause_word;
    stack_t          stack_in;
    stack_t          stack_nx;

    stack_t          stack_q;
    priv_t           priv_q;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] scause_q, sepc_q, stval_q;
    logic [XLEN-1:0] mcause_q, mepc_q, mtval_q;
    logic            done_q;

    trap_classify #(.XLEN(XLEN), .CW(CW)) u_classify (
        .async_i   (async_i),
        .cause_i   (cause_i),
        .priv_i    (priv_i),
        .badaddr_i (badaddr_i),
        .cause_o   (code),
        .tval_o    (tval)
    );

    trap_route #(.XLEN(XLEN), .CW(CW)) u_route (
        .async_i    (async_i),
        .cause_i    (code),
        .priv_i     (priv_i),
        .ideleg_i   (ideleg_i),
        .edeleg_i   (edeleg_i),
        .to_super_o (to_super)
    );

    assign tvec_sel = to_super ? stvec_i : mtvec_i;

    trap_vector #(.XLEN(XLEN), .CW(CW)) u_vector (
        .async_i  (async_i),
        .cause_i  (code),
        .tvec_i   (tvec_sel),
        .target_o (target)
    );

    always_comb begin
        stack_in   = '{sie: sie_i, spie: spie_i, spp: spp_i,
                       mie: mie_i, mpie: mpie_i, mpp: mpp_i};
        stack_nx   = push_stack(stack_in, priv_i, to_super);
        cause_word = {async_i, {PAD_W{1'b0}}, code};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stack_q  <= '0;
            priv_q   <= PRIV_M;
            pc_q     <= XLEN'(RESET_PC);
            scause_q <= '0;
            sepc_q   <= '0;
            stval_q  <= '0;
            mcause_q <= '0;
            mepc_q   <= '0;
            mtval_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= trap_valid_i;
            if (trap_valid_i) begin
                stack_q <= stack_nx;
                pc_q    <= target;
                if (to_super) begin
                    priv_q   <= PRIV_S;
                    scause_q <= cause_word;
                    sepc_q   <= pc_i;
                    stval_q  <= tval;
                end else begin
                    priv_q   <= PRIV_M;
                    mcause_q <= cause_word;
                    mepc_q   <= pc_i;
                    mtval_q  <= tval;
                end
            end
        end
    end

    assign pc_o     = pc_q;
    assign priv_o   = priv_q;
    assign sie_o    = stack_q.sie;
    assign spie_o   = stack_q.spie;
    assign spp_o    = stack_q.spp;
    assign mie_o    = stack_q.mie;
    assign mpie_o   = stack_q.mpie;
    assign mpp_o    = stack_q.mpp;
    assign scause_o = scause_q;
    assign sepc_o   = sepc_q;
    assign stval_o  = stval_q;
    assign mcause_o = mcause_q;
    assign mepc_o   = mepc_q;
    assign mtval_o  = mtval_q;
    assign done_o   = done_q;

    // R11: done follows every request by one cycle
    a_r11_done_after_req: assert property (@(posedge clk_i) disable iff (rst_i)
        trap_valid_i |=> done_o);
    a_r11_no_spurious_done: assert property (@(posedge clk_i) disable iff (rst_i)
        !trap_valid_i |=> !done_o);

    // R3: a trap from machine mode never leaves machine mode
    a_r3_machine_stays: assert property (@(posedge clk_i) disable iff (rst_i)
        (trap_valid_i && priv_i == PRIV_M) |=> (priv_o == PRIV_M));

    // R4: a supervisor commit leaves SIE cleared
    a_r4_sie_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && priv_o == PRIV_S) |-> !sie_o);

    // R5: a machine commit leaves MIE cleared
    a_r5_mie_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && priv_o == PRIV_M) |-> !mie_o);

    // R6: the machine cause top bit reflects the trap kind
    a_r6_mcause_kind: assert property (@(posedge clk_i) disable iff (rst_i)
        (trap_valid_i && !to_super) |=> (mcause_o[XLEN-1] == $past(async_i)));

    // R10: idle cycles leave pc and privilege untouched
    a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !trap_valid_i |=> ($stable(pc_o) && $stable(priv_o)));

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
    localparam int XLEN = 32;
    localparam int CW   = 6;
    localparam int unsigned RST_PC = 32'h0000_0100;

    logic            clk = 1'b0;
    logic            rst;
    logic            tv, as;
    logic [CW-1:0]   cause;
    logic [XLEN-1:0] badaddr, pc, idel, edel, stvec, mtvec;
    logic [1:0]      priv, mpp;
    logic            sie, spie, spp, mie, mpie;

    logic [XLEN-1:0] pc_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
    logic [1:0]      priv_o, mpp_o;
    logic            sie_o, spie_o, spp_o, mie_o, mpie_o, done_o;

    // expected state
    logic [XLEN-1:0] e_pc, e_scause, e_sepc, e_stval, e_mcause, e_mepc, e_mtval;
    logic [1:0]      e_priv, e_mpp;
    logic            e_sie, e_spie, e_spp, e_mie, e_mpie, e_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CW(CW), .RESET_PC(RST_PC)) u_dut (
        .clk_i(clk), .rst_i(rst), .trap_valid_i(tv), .async_i(as),
        .cause_i(cause), .badaddr_i(badaddr), .pc_i(pc), .priv_i(priv),
        .sie_i(sie), .spie_i(spie), .spp_i(spp), .mie_i(mie), .mpie_i(mpie),
        .mpp_i(mpp), .ideleg_i(idel), .edeleg_i(edel), .stvec_i(stvec),
        .mtvec_i(mtvec), .pc_o(pc_o), .priv_o(priv_o), .sie_o(sie_o),
        .spie_o(spie_o), .spp_o(spp_o), .mie_o(mie_o), .mpie_o(mpie_o),
        .mpp_o(mpp_o), .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o),
        .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic addr_cause(input int unsigned c);
        return (c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7 ||
                c == 12 || c == 13 || c == 15);
    endfunction

    task automatic compare_all();
        chk("R3 priv",     64'(priv_o),   64'(e_priv));
        chk("R7 pc",       64'(pc_o),     64'(e_pc));
        chk("R4 sie",      64'(sie_o),    64'(e_sie));
        chk("R4 spie",     64'(spie_o),   64'(e_spie));
        chk("R4 spp",      64'(spp_o),    64'(e_spp));
        chk("R5 mie",      64'(mie_o),    64'(e_mie));
        chk("R5 mpie",     64'(mpie_o),   64'(e_mpie));
        chk("R5 mpp",      64'(mpp_o),    64'(e_mpp));
        chk("R6 scause",   64'(scause_o), 64'(e_scause));
        chk("R6 mcause",   64'(mcause_o), 64'(e_mcause));
        chk("R4 sepc",     64'(sepc_o),   64'(e_sepc));
        chk("R5 mepc",     64'(mepc_o),   64'(e_mepc));
        chk("R8 stval",    64'(stval_o),  64'(e_stval));
        chk("R8 mtval",    64'(mtval_o),  64'(e_mtval));
        chk("R11 done",    64'(done_o),   64'(e_done));
    endtask

    // model one edge from current inputs, then compare at the following negedge
    task automatic step();
        int unsigned     ec;
        logic [XLEN-1:0] dl, cw, tva, vec;
        logic            tos;
        ec  = (!as && cause == 6'd8) ? int'(cause) + int'(priv) : int'(cause);
        dl  = as ? idel : edel;
        tos = (priv <= 2'd1) && (ec < XLEN) && dl[ec % XLEN];
        cw  = (as ? 32'h8000_0000 : 32'h0) | XLEN'(ec);
        tva = (!as && addr_cause(ec)) ? badaddr : '0;
        @(posedge clk);
        e_done = tv;
        if (tv) begin
            e_sie = sie; e_spie = spie; e_spp = spp;
            e_mie = mie; e_mpie = mpie; e_mpp = mpp;
            if (tos) begin
                vec = {stvec[XLEN-1:2], 2'b00} +
                      ((as && stvec[1:0] == 2'b01) ? XLEN'(ec * 4) : '0);
                e_spie = sie; e_spp = priv[0]; e_sie = 1'b0;
                e_priv = 2'd1; e_scause = cw; e_sepc = pc; e_stval = tva;
            end else begin
                vec = {mtvec[XLEN-1:2], 2'b00} +
                      ((as && mtvec[1:0] == 2'b01) ? XLEN'(ec * 4) : '0);
                e_mpie = mie; e_mpp = priv; e_mie = 1'b0;
                e_priv = 2'd3; e_mcause = cw; e_mepc = pc; e_mtval = tva;
            end
            e_pc = vec;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic setup(input logic a, input logic [CW-1:0] c, input logic [1:0] p,
                         input logic [XLEN-1:0] id, input logic [XLEN-1:0] ed);
        tv = 1'b1; as = a; cause = c; priv = p; idel = id; edel = ed;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; tv = 0; as = 0; cause = '0; badaddr = 32'hDEAD_0000;
        pc = 32'h0000_4000; priv = 2'd3; sie = 1; spie = 0; spp = 0; mie = 1;
        mpie = 0; mpp = 2'd0; idel = '0; edel = '0;
        stvec = 32'h0000_8001; mtvec = 32'h0000_C001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        e_pc = RST_PC; e_priv = 2'd3; e_sie = 0; e_spie = 0; e_spp = 0;
        e_mie = 0; e_mpie = 0; e_mpp = 0; e_scause = 0; e_sepc = 0; e_stval = 0;
        e_mcause = 0; e_mepc = 0; e_mtval = 0; e_done = 0;
        chk("R1 reset priv", 64'(priv_o), 64'd3);
        chk("R1 reset pc", 64'(pc_o), 64'(RST_PC));
        chk("R1 reset done", 64'(done_o), 64'd0);
        compare_all();

        // R9: ecall from supervisor recoded to 9, delegated through bit 9 only
        setup(0, 6'd8, 2'd1, '0, 32'h0000_0200);
        step();
        chk("R9 ecall from S to supervisor", 64'(priv_o), 64'd1);
        chk("R9 ecall code 9", 64'(scause_o), 64'd9);

        // R9: ecall from user with only bit 8 delegated
        setup(0, 6'd8, 2'd0, '0, 32'h0000_0100);
        step();
        chk("R9 ecall code 8", 64'(scause_o), 64'd8);

        // R9/R3: ecall from machine stays in machine even if bit 11 delegated
        setup(0, 6'd8, 2'd3, '0, 32'hFFFF_FFFF);
        step();
        chk("R9 ecall code 11", 64'(mcause_o), 64'd11);

        // R2: interrupt uses ideleg only (edeleg clear)
        setup(1, 6'd5, 2'd0, 32'h0000_0020, '0);
        step();
        chk("R2 interrupt delegated", 64'(priv_o), 64'd1);
        chk("R7 vectored offset", 64'(pc_o), 64'h0000_8000 + 64'd20);
        // R2: exception with same cause ignores ideleg
        setup(0, 6'd5, 2'd0, 32'h0000_0020, '0);
        step();
        chk("R2 exception not delegated", 64'(priv_o), 64'd3);
        chk("R8 access fault tval", 64'(mtval_o), 64'hDEAD_0000);

        // R3: cause at or above XLEN never delegated
        setup(1, 6'd40, 2'd0, '1, '1);
        step();
        chk("R3 cause above XLEN", 64'(priv_o), 64'd3);

        // R8: interrupt 13 yields zero trap value
        setup(1, 6'd13, 2'd3, '0, '0);
        step();
        chk("R8 interrupt tval zero", 64'(mtval_o), 64'd0);

        // R10: idle cycle holds everything
        tv = 0; pc = 32'h1234_5678; priv = 2'd0;
        step();
        chk("R10 idle pc hold", 64'(pc_o), 64'(e_pc));
        chk("R11 idle done low", 64'(done_o), 64'd0);

        // random vectors
        for (int i = 0; i < 3000; i++) begin
            tv    = ($urandom % 4) != 0;
            as    = $urandom % 2;
            cause = ($urandom % 3 == 0) ? CW'($urandom) : CW'($urandom % 16);
            priv  = 2'($urandom);
            badaddr = $urandom; pc = $urandom;
            sie = $urandom % 2; spie = $urandom % 2; spp = $urandom % 2;
            mie = $urandom % 2; mpie = $urandom % 2; mpp = 2'($urandom);
            idel = $urandom; edel = $urandom;
            stvec = $urandom; mtvec = $urandom;
            if ($urandom % 2 == 1) stvec[1:0] = 2'b01;
            if ($urandom % 2 == 1) mtvec[1:0] = 2'b01;
            step();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule